// File: doc/BRIEF.md
# Printer Port Register Block

This block is a byte-wide register file for a standard printer port that sits on a simple single-cycle peripheral bus. Three registers are decoded from the low three address bits: data at offset 0, status at offset 1 and control at offset 2. The block also stands in for the printer's side of the handshake. Control writes drive the strobe, initialise and select lines, and these step an internal busy/acknowledge pattern. Status reads then advance that pattern the way a polling driver would see it.

Each byte strobed out by software appears on a byte stream output with a one-cycle valid pulse. A byte arriving on the input stream is latched and can be read back when the port is set to the input direction. A registered, level-sensitive interrupt line reflects a pending flag. A strobe release with interrupts enabled sets that flag, and any status read clears it.

Top module: `prn_port_regs`

## Requirements
- R1: After reset the written-data and input-data registers both hold 0xFF, status reads 0xD9, control reads 0xCC, and irq and out_valid are 0.
- R2: A write at offset 0 stores the byte. A read at offset 0 returns that byte when control bit 5 (direction) is 0. When bit 5 is 1 it returns the byte most recently presented with in_valid.
- R3: A write at offset 2 stores the byte with bits 7 and 6 forced to 1, and a read at offset 2 returns the stored value.
- R4: A control write whose bit 2 (initialise) is 0 loads status with 0xD8: bit 7 not-busy, bit 6 acknowledge, bit 4 online and bit 3 not-error set, with bit 0 (timeout) cleared.
- R5: A control write with bit 2 = 1, bit 3 (select) = 1 and bit 0 (strobe) = 1 clears status bit 7. If the previously stored bit 0 was 0, the stored data byte is also driven on out_byte, with out_valid high for exactly the next cycle. Otherwise nothing is emitted.
- R6: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 sets the pending flag if the previously stored control bit 4 (interrupt enable) is 1.
- R7: A read at offset 1 returns the status as it was before the read and clears the pending flag.
- R8: A status read taken while status bit 7 is 0 and stored control bit 0 is 0 steps the pattern afterwards. If bit 6 was 1 it is cleared. If bit 6 was 0, bits 6 and 7 are both set. Otherwise status is unchanged by the read.
- R9: Reads at offsets 3 to 7 return 0xFF. Writes at offset 1 and at offsets 3 to 7 change no register.
- R10: irq is a register equal to the pending flag, so it changes on the clock edge that ends the bus access that sets or clears the flag.
- R11: Read data appears on rdata in the cycle after rd_en and is held until the next read. A write in the same cycle takes priority, and the read is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | One-cycle pulse for an emitted byte |
| out_byte | output | 8 | Emitted byte |
| irq | output | 1 | Level interrupt |

## Verification
A wrong status or control state shows up on the very next read of that offset. It also corrupts later steps of the acknowledge pattern, so every status read is compared against an independently stepped expectation. A wrong stored strobe bit shows up one cycle after the next strobe write, as a missing or extra out_valid pulse. A wrong pending flag shows on irq one cycle after the access that should have changed it. The bench therefore sweeps every control byte across both prior strobe states and both interrupt-enable states, following each write with control and status reads.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int BYTE_W = 8;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;

  // control bit positions
  localparam int C_STROBE = 0;
  localparam int C_INIT   = 2;
  localparam int C_SELECT = 3;
  localparam int C_IEN    = 4;
  localparam int C_DIR    = 5;

  // status bit positions
  localparam int S_ACK     = 6;
  localparam int S_NOTBUSY = 7;

  localparam logic [7:0] STAT_RESET = 8'hD9;
  localparam logic [7:0] STAT_INIT  = 8'hD8;
  localparam logic [7:0] CTRL_RESET = 8'hCC;
  localparam logic [7:0] BYTE_IDLE  = 8'hFF;

  function automatic logic [7:0] ctrl_fix(input logic [7:0] w);
    return w | 8'hC0;
  endfunction

  // status after a status read, given the stored strobe bit
  function automatic logic [7:0] stat_step(input logic [7:0] st, input logic strobe);
    logic [7:0] n;
    n = st;
    if (!st[S_NOTBUSY] && !strobe) begin
      if (st[S_ACK]) n[S_ACK] = 1'b0;
      else begin
        n[S_ACK] = 1'b1;
        n[S_NOTBUSY] = 1'b1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/prn_ctrl_reg.sv
module prn_ctrl_reg
  import prn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl_q,
  output logic       ev_init,
  output logic       ev_strobe_hi,
  output logic       ev_emit,
  output logic       ev_irq_set
);
  logic armed;
  assign armed        = wr_ctrl && wdata[C_INIT] && wdata[C_SELECT];
  assign ev_init      = wr_ctrl && !wdata[C_INIT];
  assign ev_strobe_hi = armed && wdata[C_STROBE];
  assign ev_emit      = ev_strobe_hi && !ctrl_q[C_STROBE];
  assign ev_irq_set   = armed && !wdata[C_STROBE] && ctrl_q[C_IEN];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else if (wr_ctrl) ctrl_q <= ctrl_fix(wdata);
  end
endmodule

// File: rtl/prn_status_seq.sv
module prn_status_seq
  import prn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_init,
  input  logic       ev_strobe_hi,
  input  logic       rd_stat,
  input  logic       strobe_q,
  output logic [7:0] status_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= STAT_RESET;
    else if (ev_init) status_q <= STAT_INIT;
    else if (ev_strobe_hi) status_q[S_NOTBUSY] <= 1'b0;
    else if (rd_stat) status_q <= stat_step(status_q, strobe_q);
  end
endmodule

// File: rtl/prn_read_mux.sv
module prn_read_mux
  import prn_pkg::*;
(
  input  logic [2:0] addr,
  input  logic [7:0] data_w,
  input  logic [7:0] data_r,
  input  logic [7:0] status_q,
  input  logic [7:0] ctrl_q,
  output logic [7:0] value
);
  always_comb begin
    unique case (addr)
      OFS_DATA: value = ctrl_q[C_DIR] ? data_r : data_w;
      OFS_STAT: value = status_q;
      OFS_CTRL: value = ctrl_q;
      default:  value = BYTE_IDLE;
    endcase
  end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       irq
);
  logic [7:0] data_w, data_r, ctrl_q, status_q, rd_value;
  logic wr_ctrl, rd_eff, rd_stat;
  logic ev_init, ev_strobe_hi, ev_emit, ev_irq_set;
  logic pend;

  assign wr_ctrl = wr_en && (addr == OFS_CTRL);
  assign rd_eff  = rd_en && !wr_en;
  assign rd_stat = rd_eff && (addr == OFS_STAT);

  prn_ctrl_reg u_ctrl (
    .clk, .rst_n, .wr_ctrl, .wdata, .ctrl_q,
    .ev_init, .ev_strobe_hi, .ev_emit, .ev_irq_set
  );

  prn_status_seq u_stat (
    .clk, .rst_n, .ev_init, .ev_strobe_hi, .rd_stat,
    .strobe_q(ctrl_q[C_STROBE]), .status_q
  );

  prn_read_mux u_mux (
    .addr, .data_w, .data_r, .status_q, .ctrl_q, .value(rd_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_w    <= BYTE_IDLE;
      data_r    <= BYTE_IDLE;
      rdata     <= BYTE_IDLE;
      out_valid <= 1'b0;
      out_byte  <= BYTE_IDLE;
      pend      <= 1'b0;
    end else begin
      if (wr_en && addr == OFS_DATA) data_w <= wdata;
      if (in_valid) data_r <= in_byte;
      if (rd_eff) rdata <= rd_value;
      out_valid <= ev_emit;
      if (ev_emit) out_byte <= data_w;
      if (ev_irq_set) pend <= 1'b1;
      else if (rd_stat) pend <= 1'b0;
    end
  end

  assign irq = pend;
endmodule

// File: rtl/prn_port_regs_chk.sv
module prn_port_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic       out_valid,
  input logic       irq,
  input logic [7:0] ctrl_q,
  input logic [7:0] status_q
);
  // R3
  a_r3_ctrl_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> ctrl_q == ($past(wdata) | 8'hC0));
  // R4
  a_r4_init_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2 && !wdata[2]) |=> status_q == 8'hD8);
  // R5
  a_r5_emit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(wr_en && addr == 3'd2 && wdata[3] && wdata[2] && wdata[0] && !ctrl_q[0]));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R7
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 3'd1) |=> !irq);
  // R9
  a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1) |=> $stable(status_q));
  // R10
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en && addr == 3'd2 && wdata[3] && wdata[2] && !wdata[0] && ctrl_q[4]));
endmodule

bind prn_port_regs prn_port_regs_chk u_chk (
  .clk, .rst_n, .addr, .wr_en, .rd_en, .wdata, .out_valid, .irq,
  .ctrl_q, .status_q
);

// File: tb/prn_port_regs_tb.sv
module prn_port_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, in_valid = 1'b0;
  logic [7:0] wdata = '0, in_byte = '0;
  logic [7:0] rdata, out_byte;
  logic out_valid, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_dw, m_dr, m_st, m_ct, m_last_rd;
  bit m_pend;

  always #2.5 clk = ~clk;

  prn_port_regs u_dut (
    .clk, .rst_n, .addr, .wr_en, .rd_en, .wdata, .rdata,
    .in_valid, .in_byte, .out_valid, .out_byte, .irq
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one bus access; results sampled at the following falling edge
  task automatic op(input bit w, input bit r, input logic [2:0] a, input logic [7:0] d);
    bit ev, ir_set;
    logic [7:0] eb, rv, fixed;
    ev = 0; eb = 8'h00; ir_set = 0;
    rv = m_last_rd;
    if (w) begin
      if (a == 3'd0) m_dw = d;
      else if (a == 3'd2) begin
        fixed = {2'b11, d[5:0]};
        if (d[2] == 1'b0) m_st = 8'hD8;
        else if (d[3]) begin
          if (d[0]) begin
            m_st[7] = 1'b0;
            if (m_ct[0] == 1'b0) begin ev = 1; eb = m_dw; end
          end else if (m_ct[4]) ir_set = 1;
        end
        if (ir_set) m_pend = 1;
        m_ct = fixed;
      end
    end else if (r) begin
      case (a)
        3'd0: rv = m_ct[5] ? m_dr : m_dw;
        3'd1: begin
          rv = m_st;
          m_pend = 0;
          if (m_st[7] == 1'b0 && m_ct[0] == 1'b0) begin
            if (m_st[6]) m_st[6] = 1'b0;
            else m_st = m_st | 8'hC0;
          end
        end
        3'd2: rv = m_ct;
        default: rv = 8'hFF;
      endcase
      m_last_rd = rv;
    end
    addr = a; wr_en = w; rd_en = r; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R11 rdata", rdata, rv);
    chk("R5 out_valid", {7'd0, out_valid}, {7'd0, ev});
    if (ev) chk("R5 out_byte", out_byte, eb);
    chk("R10 irq", {7'd0, irq}, {7'd0, m_pend});
  endtask

  task automatic feed(input logic [7:0] b);
    in_valid = 1; in_byte = b; m_dr = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    m_dw = 8'hFF; m_dr = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC; m_pend = 0; m_last_rd = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 out_valid", {7'd0, out_valid}, 8'h00);
    op(0, 1, 3'd1, 8'h00); chk("R1 status", rdata, 8'hD9);
    op(0, 1, 3'd2, 8'h00); chk("R1 control", rdata, 8'hCC);
    op(0, 1, 3'd0, 8'h00); chk("R1 data", rdata, 8'hFF);
    // R9 unmapped reads and ignored writes
    for (int a = 3; a < 8; a++) begin
      op(1, 0, a[2:0], 8'h00);
      op(0, 1, a[2:0], 8'h00); chk("R9 unmapped", rdata, 8'hFF);
    end
    op(1, 0, 3'd1, 8'h00);
    op(0, 1, 3'd1, 8'h00); chk("R9 status write ignored", rdata, m_last_rd);
    // R2 data path, both directions
    for (int v = 0; v < 256; v += 17) begin
      op(1, 0, 3'd0, v[7:0]);
      feed(~v[7:0]);
      op(1, 0, 3'd2, 8'h2C);
      op(0, 1, 3'd0, 8'h00); chk("R2 dir=1 input byte", rdata, ~v[7:0]);
      op(1, 0, 3'd2, 8'h0C);
      op(0, 1, 3'd0, 8'h00); chk("R2 dir=0 written byte", rdata, v[7:0]);
    end
    // R3..R8 sweep every control byte from each prior strobe/ien state
    for (int pre = 0; pre < 4; pre++) begin
      for (int c = 0; c < 256; c++) begin
        op(1, 0, 3'd2, {3'b000, pre[1], 1'b1, 1'b1, 1'b0, pre[0]});
        op(1, 0, 3'd0, c[7:0] ^ 8'hA5);
        op(1, 0, 3'd2, c[7:0]);          // R4 R5 R6 via model
        op(0, 1, 3'd2, 8'h00);           // R3
        op(0, 1, 3'd1, 8'h00);           // R7 R8
        op(0, 1, 3'd1, 8'h00);           // R8 second step
        op(0, 1, 3'd1, 8'h00);           // R8 third step
      end
    end
    // R6/R10 explicit: pending stays until a status read
    op(1, 0, 3'd2, 8'h1D);
    op(1, 0, 3'd2, 8'h1C); chk("R6 pending set", {7'd0, irq}, 8'h01);
    op(0, 1, 3'd2, 8'h00); chk("R10 irq held", {7'd0, irq}, 8'h01);
    op(0, 1, 3'd1, 8'h00); chk("R7 pending cleared", {7'd0, irq}, 8'h00);
    // R11 write wins over simultaneous read
    op(1, 1, 3'd0, 8'h3C); chk("R11 read ignored", rdata, m_last_rd);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule